// File: doc/BRIEF.md
# Quasi-Cyclic LDPC Parity Encoder

This block turns a message into the parity part of a quasi-cyclic LDPC code word without any generator matrix. The code word is 24 sub-blocks of z bits each. The first kb sub-blocks are the message. The last mb sub-blocks are parity, where mb is set by the code rate. The block works from a base parity-check matrix held in an internal lookup function. Each base entry is either null or a circular shift amount. The block reads one entry per clock.

A host fills a message buffer with kb sub-blocks. The block addresses that buffer through `msg_addr`, and `msg_data` must return the addressed sub-block in the same cycle. The host then pulses `start`, with the code rate and z presented on the same cycle.

The block works in two phases:
- **Forward pass.** For each base row it accumulates a row sum from the shifted message sub-blocks. It keeps the row sums in a small local store and folds them into the first parity sub-block.
- **Backward pass.** It then runs back through the dual-diagonal part of the matrix, from the last parity to the second one. Each row sum is overwritten in place by its parity.

Every parity sub-block leaves through a single write port (`par_we`, `par_addr`, `par_data`). A one-cycle `done` pulse closes the run.

Top module: `qc_ldpc_parity_enc`

## Requirements
- R1: While reset is held, and afterwards until a start is accepted, `done` and `par_we` are 0. A reset in the middle of a run abandons it: no further parity write and no `done` follow.
- R2: `cfg_rate` values 0, 1, 2 and 3 select mb = 12, 8, 6 and 4 base rows, with kb = 24 − mb. The base entry at row i, column j < kb is null when (5i+3j+rate) mod 4 = 0, and otherwise is (29i+13j+7·rate) mod 96. Column kb holds 60+rate in row 0 and in row mb−1, holds 0 in row mb/2, and is null elsewhere. Column kb+t (t ≥ 1) holds 0 in rows t−1 and t, and is null elsewhere.
- R3: Entries are defined for z = 96. For the configured z, an entry P > 0 is used as floor(P·z/96). Entries equal to 0, and null entries, are used as they are.
- R4: Applying an entry s to a z-bit sub-block v gives output bit b = v[(b+s) mod z]. A null entry gives zero. The code word c = [u0 … u(kb−1), p0 … p(mb−1)] satisfies H·c = 0 over GF(2) for every base row and every bit.
- R5: A run makes exactly mb parity writes, in this address order: p0 at address 0 first, then addresses mb−1, mb−2, … down to 1, one write per cycle from the second write onward.
- R6: `done` is high for exactly one cycle. That cycle is the one right after the cycle in which p1 (address 1) is written.
- R7: Rate and z are sampled together with an accepted `start`. A `start`, or any change of configuration, while a run is in progress has no effect: the run completes as configured, with a single `done` and mb writes.
- R8: Message bits at positions z and above are ignored. Parity bits at positions z and above are written as 0.
- R9: Counting the cycle in which `start` is high as cycle 0, `done` is high in cycle mb·(kb+2)+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a run when the block is idle |
| cfg_rate | input | 2 | Code-rate select (0..3 gives mb = 12, 8, 6, 4) |
| cfg_z | input | ZW (7) | Expansion factor z, from 1 to ZMAX |
| done | output | 1 | One-cycle end-of-run pulse |
| msg_addr | output | CW (5) | Message sub-block index being read |
| msg_data | input | ZMAX (96) | Addressed message sub-block, same cycle |
| par_we | output | 1 | Parity write strobe |
| par_addr | output | RW (4) | Parity sub-block index |
| par_data | output | ZMAX (96) | Parity sub-block value |

## Verification
A wrong row sum, a wrong shift or a stale accumulator cannot hide. It corrupts every parity produced after it in the backward recursion, so a failed check of H times the code word shows up on the first run that uses the faulty row. A miscounted row or column moves `done` off its exact latency, or breaks the descending write-address sequence, within that same run. Leakage of a state from one run to the next appears as an extra write or an extra `done` in the idle cycles that the bench watches after each run.

// File: rtl/qc_ldpc_parity_enc.sv
module qc_ldpc_parity_enc #(
  parameter int ZMAX = 96,
  parameter int ZREF = 96,
  parameter int ZW   = $clog2(ZMAX + 1),
  parameter int CW   = 5,
  parameter int RW   = 4
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      cfg_rate,
  input  logic [ZW-1:0]   cfg_z,
  output logic            done,
  output logic [CW-1:0]   msg_addr,
  input  logic [ZMAX-1:0] msg_data,
  output logic            par_we,
  output logic [RW-1:0]   par_addr,
  output logic [ZMAX-1:0] par_data
);
  localparam int NB    = 24;
  localparam int MBMAX = NB / 2;
  localparam int IW    = (ZMAX > 1) ? $clog2(ZMAX) : 1;

  typedef enum logic [2:0] {S_WAIT, S_START, S_ROW, S_STORE, S_LAST, S_PAR} st_t;

  st_t             st;
  logic [1:0]      rate_q;
  logic [ZW-1:0]   z_q;
  logic [RW-1:0]   row;
  logic [CW-1:0]   col;
  logic [ZMAX-1:0] rs, acc, pn, term, p0_term;
  logic [ZMAX-1:0] lam [MBMAX];
  int              mb, kb, zi, ent, sh;

  function automatic int rows_of(input logic [1:0] r);
    case (r)
      2'd0:    return 12;
      2'd1:    return 8;
      2'd2:    return 6;
      default: return 4;
    endcase
  endfunction

  function automatic int base_entry(input int r, input int i, input int j, input int m);
    if (j < NB - m) begin
      if ((5*i + 3*j + r) % 4 == 0) return -1;
      return (29*i + 13*j + 7*r) % ZREF;
    end
    if (i == 0 || i == m - 1) return 60 + r;
    if (i == m / 2) return 0;
    return -1;
  endfunction

  function automatic int scaled(input int p, input int z);
    if (p > 0) return (p * z) / ZREF;
    return p;
  endfunction

  function automatic logic [ZMAX-1:0] rotl(input logic [ZMAX-1:0] v, input int s, input int z);
    logic [ZMAX-1:0] r;
    int k;
    r = '0;
    for (int b = 0; b < ZMAX; b++) begin
      if (b < z) begin
        k = b + s;
        if (k >= z) k = k - z;
        r[b] = v[k[IW-1:0]];
      end
    end
    return r;
  endfunction

  assign msg_addr = col;

  always_comb begin
    mb      = rows_of(rate_q);
    kb      = NB - mb;
    zi      = int'(z_q);
    ent     = base_entry(int'(rate_q), int'(row), (st == S_ROW) ? int'(col) : kb, mb);
    sh      = scaled(ent, zi);
    term    = (ent < 0) ? '0 : rotl(msg_data, sh, zi);
    p0_term = (ent < 0) ? '0 : rotl(acc, sh, zi);
    par_we  = (st == S_STORE && int'(row) == mb - 1) || st == S_LAST || st == S_PAR;
    par_addr = (st == S_STORE) ? '0 : row;
    case (st)
      S_STORE: par_data = acc ^ rs;
      S_LAST:  par_data = rs ^ p0_term;
      S_PAR:   par_data = lam[row] ^ pn ^ p0_term;
      default: par_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_WAIT;
      rate_q <= '0;
      z_q    <= '0;
      row    <= '0;
      col    <= '0;
      rs     <= '0;
      acc    <= '0;
      pn     <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_WAIT: if (start) begin
          rate_q <= cfg_rate;
          z_q    <= cfg_z;
          st     <= S_START;
        end
        S_START: begin
          row <= '0;
          col <= '0;
          rs  <= '0;
          acc <= '0;
          st  <= S_ROW;
        end
        S_ROW: begin
          rs <= rs ^ term;
          if (int'(col) == kb - 1) st <= S_STORE;
          else col <= col + 1'b1;
        end
        S_STORE: begin
          acc <= acc ^ rs;
          if (int'(row) == mb - 1) st <= S_LAST;
          else begin
            rs  <= '0;
            row <= row + 1'b1;
            col <= '0;
            st  <= S_ROW;
          end
        end
        S_LAST: begin
          rs  <= par_data;
          pn  <= par_data;
          row <= row - 1'b1;
          st  <= S_PAR;
        end
        S_PAR: begin
          pn <= par_data;
          if (row == RW'(1)) begin
            done <= 1'b1;
            st   <= S_WAIT;
          end else row <= row - 1'b1;
        end
        default: st <= S_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_STORE && int'(row) != mb - 1) lam[row] <= rs;
    else if (st == S_PAR) lam[row] <= par_data;
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_p1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(par_we) && $past(par_addr) == RW'(1)));

  assert_write_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (par_we && $past(par_we)) |->
      (($past(par_addr) == '0) ? (int'(par_addr) == mb - 1)
                               : (par_addr == $past(par_addr) - 1'b1)));

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    par_we |-> ((par_data >> zi) == '0));

  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st != S_WAIT) |=> (st != S_START));

  assert_msg_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ROW) |-> (int'(msg_addr) < kb));
endmodule

// File: tb/sim_qc_ldpc_parity_enc.sv
module sim_qc_ldpc_parity_enc;
  localparam int ZM = 16;
  localparam int ZW = $clog2(ZM + 1);
  localparam int NV = 10;
  localparam int VEC [NV][3] = '{
    '{0, 16, 11}, '{1, 16, 22}, '{2, 16, 33}, '{3, 16, 44}, '{0, 12, 55},
    '{1, 8, 66},  '{2, 5, 77},  '{3, 1, 88},  '{0, 7, 99},  '{3, 13, 100}};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] cfg_rate = '0;
  logic [ZW-1:0] cfg_z = ZW'(ZM);
  logic done, par_we;
  logic [4:0] msg_addr;
  logic [3:0] par_addr;
  logic [ZM-1:0] msg_data, par_data;
  logic [ZM-1:0] msg [24];
  logic [ZM-1:0] par [16];

  int errs = 0, checks = 0;
  int cyc = 0, wr_cnt = 0, done_cnt = 0, done_cyc = 0, s_cyc = 0, last_wr_cyc = 0, upper_cnt = 0;
  int cur_z = ZM;
  int wr_log [256];
  logic start_d = 1'b0;

  assign msg_data = (msg_addr < 5'd24) ? msg[msg_addr] : '0;

  qc_ldpc_parity_enc #(.ZMAX(ZM)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_rate(cfg_rate), .cfg_z(cfg_z),
    .done(done), .msg_addr(msg_addr), .msg_data(msg_data),
    .par_we(par_we), .par_addr(par_addr), .par_data(par_data));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (par_we) begin
      wr_log[wr_cnt % 256] = int'(par_addr);
      wr_cnt++;
      par[par_addr] = par_data;
      last_wr_cyc = cyc;
      if ((par_data >> cur_z) != '0) upper_cnt++;
    end
    if (done) begin
      done_cnt++;
      done_cyc = cyc;
    end
    if (start && !start_d) s_cyc = cyc;
    start_d = start;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rows(input int r);
    return (r == 0) ? 12 : (r == 1) ? 8 : (r == 2) ? 6 : 4;
  endfunction

  function automatic int hent(input int r, input int i, input int j, input int m);
    int k = 24 - m;
    if (j < k) return ((5*i + 3*j + r) % 4 == 0) ? -1 : (29*i + 13*j + 7*r) % 96;
    if (j == k) begin
      if (i == 0 || i == m - 1) return 60 + r;
      return (i == m / 2) ? 0 : -1;
    end
    return (i == j - k - 1 || i == j - k) ? 0 : -1;
  endfunction

  function automatic int violations(input int r, input int z);
    int m = rows(r), k = 24 - m, cnt = 0;
    for (int i = 0; i < m; i++)
      for (int b = 0; b < z; b++) begin
        logic s = 1'b0;
        for (int j = 0; j < 24; j++) begin
          int e = hent(r, i, j, m);
          if (e >= 0) begin
            int q;
            if (e > 0) e = (e * z) / 96;
            q = (b + e) % z;
            s = s ^ ((j < k) ? msg[j][q] : par[j - k][q]);
          end
        end
        if (s) cnt++;
      end
    return cnt;
  endfunction

  task automatic fill(input int seed);
    for (int j = 0; j < 24; j++) begin
      logic [31:0] h;
      h = 32'(seed) * 32'h9E3779B1 + 32'(j) * 32'h7F4A7C15;
      h = h ^ (h >> 15);
      h = h * 32'h2C1B3C6D;
      h = h ^ (h >> 12);
      msg[j] = h[ZM-1:0];
    end
  endtask

  task automatic run(input int r, input int z, input int seed, input bit busy);
    int m = rows(r), k = 24 - m, w0, d0, u0b, t, bad;
    fill(seed);
    @(posedge clk); #1;
    w0 = wr_cnt; d0 = done_cnt; u0b = upper_cnt;
    cur_z = z;
    cfg_rate = 2'(r); cfg_z = ZW'(z); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (busy) begin
      repeat (6) @(posedge clk);
      #1;
      start = 1'b1; cfg_rate = 2'(r + 1); cfg_z = ZW'((z > 2) ? z - 2 : z + 1);
      repeat (3) @(posedge clk);
      #1;
      start = 1'b0;
    end
    t = 0;
    while (done_cnt == d0 && t < 4000) begin
      @(posedge clk);
      t++;
    end
    check(t < 4000, "R6", "done seen before run timeout", t, 0);
    repeat (20) @(posedge clk);
    if (!busy)
      check(done_cyc - s_cyc == m * (k + 2) + 1, "R9", "start-to-done cycles",
            done_cyc - s_cyc, m * (k + 2) + 1);
    check(done_cnt - d0 == 1, busy ? "R7" : "R6", "done pulses in run", done_cnt - d0, 1);
    check(done_cyc == last_wr_cyc + 1 && wr_log[(wr_cnt + 255) % 256] == 1, "R6",
          "done one cycle after p1 write", done_cyc - last_wr_cyc, 1);
    bad = (wr_cnt - w0 == m) ? 0 : 1;
    if (!bad)
      for (int n = 0; n < m; n++)
        if (wr_log[(w0 + n) % 256] != ((n == 0) ? 0 : m - n)) bad++;
    check(bad == 0, busy ? "R7" : "R5", "write count and address order", wr_cnt - w0, m);
    check(upper_cnt == u0b, "R8", "parity bits above z zero", upper_cnt - u0b, 0);
    t = violations(r, z);
    check(t == 0, "R2/R3/R4", $sformatf("H*c rate=%0d z=%0d", r, z), t, 0);
  endtask

  initial begin
    #(4 * 150000);
    checks++; errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int w0, d0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0 && par_we == 1'b0, "R1", "outputs during reset", int'({done, par_we}), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0 && par_we == 1'b0 && wr_cnt == 0, "R1", "idle after reset", wr_cnt, 0);

    for (int n = 0; n < NV; n++) run(VEC[n][0], VEC[n][1], VEC[n][2], 1'b0);

    run(1, 14, 123, 1'b1);
    run(2, 9, 321, 1'b1);

    fill(7);
    @(posedge clk); #1;
    cfg_rate = 2'd0; cfg_z = ZW'(ZM); cur_z = ZM; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (150) @(posedge clk);
    #1;
    rst_n = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && par_we == 1'b0, "R1", "outputs in mid-run reset", int'({done, par_we}), 0);
    w0 = wr_cnt; d0 = done_cnt;
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (300) @(posedge clk);
    check(wr_cnt == w0 && done_cnt == d0, "R1", "no writes after abandoned run", wr_cnt - w0, 0);

    run(3, 16, 555, 1'b0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule